// File: doc/BRIEF.md
# Trap entry and delegation unit

This block computes the machine state that follows a trap. When a trap strobe arrives, it takes the trap's cause code, an interrupt flag, the faulting address, the PC of the trapping instruction, the current privilege, the current status enable bits and the two delegation masks. It decides whether the supervisor level or the machine level handles the trap. It then registers the new cause, exception-PC and trap-value words for that level, the updated status image, the new privilege and a redirect PC taken from that level's trap vector base.

A CSR file around the block feeds it the current status bits, delegation masks and vector bases. The CSR file takes the block's registered outputs back as the post-trap state, and the fetch unit follows the one-cycle redirect pulse. Outputs belonging to the level that did not take the trap keep their previous values. The status fields owned by that level are passed through from the status input.

Top module: `trap_entry_unit`

## Requirements
- R1: Privilege is encoded U=0, S=1, M=3. A trap goes to S (priv_o=1) only if priv_i is U or S, the effective cause is below 32, and the selected delegation mask has the bit at the effective cause set. In every other case it goes to M (priv_o=3), and this includes any trap taken while in M.
- R2: An interrupt (trap_irq_i=1) selects ideleg_i. An exception selects edeleg_i.
- R3: An exception with cause 8 is an environment call. Its effective cause becomes 8 from U, 9 from S and 11 from M, and that value is used for delegation and reporting. Interrupt cause 8 is not remapped.
- R4: The handling level's cause word is the effective cause zero-extended to 32 bits, with bit 31 set to the interrupt flag.
- R5: status_o layout: bit0 S enable, bit1 M enable, bit2 S previous enable, bit3 M previous enable, bit4 S previous privilege, bits6:5 M previous privilege. On a trap, the handling level's previous enable takes its current enable, its previous privilege takes priv_i, and its enable is cleared. The other level's fields are copied from status_i.
- R6: The handling level's trap-value word is trap_addr_i for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is zero for every interrupt and every other cause.
- R7: The handling level's exception-PC word takes trap_pc_i.
- R8: redir_pc_o is the handling level's vector base with bits 1:0 cleared. When the base's bits 1:0 equal 1 and the trap is an interrupt, 4 times the effective cause is added.
- R9: redir_valid_o is high for exactly the cycle after each cycle with trap_valid_i high, and it carries that trap's redirect PC.
- R10: Cause, exception-PC and trap-value words of the level that did not handle a trap keep their values. Without a trap strobe, no output other than redir_valid_o changes.
- R11: After reset, priv_o is 3 and every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap strobe, one cycle per trap |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_cause_i | input | 6 | Raw cause code |
| trap_addr_i | input | 32 | Faulting address |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege |
| status_i | input | 7 | Current status image (layout in R5) |
| edeleg_i | input | 32 | Exception delegation mask |
| ideleg_i | input | 32 | Interrupt delegation mask |
| svec_i | input | 32 | Supervisor vector base and mode bits |
| mvec_i | input | 32 | Machine vector base and mode bits |
| status_o | output | 7 | Status image after the last trap |
| priv_o | output | 2 | Privilege after the last trap |
| scause_o | output | 32 | Supervisor cause word |
| sepc_o | output | 32 | Supervisor exception PC |
| stval_o | output | 32 | Supervisor trap value |
| mcause_o | output | 32 | Machine cause word |
| mepc_o | output | 32 | Machine exception PC |
| mtval_o | output | 32 | Machine trap value |
| redir_valid_o | output | 1 | Redirect pulse |
| redir_pc_o | output | 32 | Redirect target |

## Verification
On every cycle the assertions check the following:
- the one-cycle redirect pulse and its word alignment;
- that a trap from M stays in M;
- that the handling level's enable bit is cleared and its exception PC captured;
- the interrupt bit of the cause word;
- that nothing moves between traps.

Some behaviours only the bench's scenarios can show, because they depend on the exact choice of level and values:
- delegation by mask bit, including causes of 32 and above whose low bits alias a set mask bit;
- the environment-call remap by privilege;
- which causes keep a trap value;
- the vectored offset, which applies to interrupts only and only for mode 1.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int ST_W    = 7;
    localparam int ST_SIE  = 0;
    localparam int ST_MIE  = 1;
    localparam int ST_SPIE = 2;
    localparam int ST_MPIE = 3;
    localparam int ST_SPP  = 4;
    localparam int ST_MPP  = 5;

    localparam int ECALL_FROM_U = 8;
    localparam int ECALL_FROM_S = 9;
    localparam int ECALL_FROM_M = 11;
endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter int               CAUSE_W   = 6,
    parameter logic [XLEN-1:0]  TVAL_MASK = 32'h0000_B0F3
) (
    input  logic                irq_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic [1:0]          priv_i,
    input  logic [XLEN-1:0]     edeleg_i,
    input  logic [XLEN-1:0]     ideleg_i,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic                to_s_o,
    output logic                keep_tval_o
);
    localparam int IDX_W = $clog2(XLEN);

    logic               is_ecall;
    logic               in_range;
    logic               low_priv;
    logic [XLEN-1:0]    mask;
    logic [IDX_W-1:0]   idx;

    always_comb begin
        is_ecall = !irq_i && (cause_i == CAUSE_W'(ECALL_FROM_U));
        cause_o  = cause_i;
        if (is_ecall) begin
            case (priv_i)
                PRIV_M:  cause_o = CAUSE_W'(ECALL_FROM_M);
                PRIV_S:  cause_o = CAUSE_W'(ECALL_FROM_S);
                default: cause_o = CAUSE_W'(ECALL_FROM_U);
            endcase
        end
        in_range    = ({1'b0, cause_o} < (CAUSE_W+1)'(XLEN));
        idx         = cause_o[IDX_W-1:0];
        mask        = irq_i ? ideleg_i : edeleg_i;
        low_priv    = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_s_o      = low_priv && in_range && mask[idx];
        keep_tval_o = !irq_i && in_range && TVAL_MASK[idx];
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 6,
    parameter bit VECTORED = 1'b1
) (
    input  logic [XLEN-1:0]     base_i,
    input  logic                irq_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    output logic [XLEN-1:0]     pc_o
);
    logic [XLEN-1:0] aligned;
    assign aligned = {base_i[XLEN-1:2], 2'b00};

    generate
        if (VECTORED) begin : g_vectored
            logic [XLEN-1:0] offset;
            assign offset = (irq_i && (base_i[1:0] == 2'b01))
                          ? {{(XLEN-CAUSE_W-2){1'b0}}, cause_i, 2'b00}
                          : '0;
            assign pc_o = aligned + offset;
        end else begin : g_direct
            assign pc_o = aligned;
        end
    endgenerate
endmodule

// File: rtl/trap_status.sv
module trap_status
    import trap_pkg::*;
(
    input  logic             to_s_i,
    input  logic [1:0]       priv_i,
    input  logic [ST_W-1:0]  status_i,
    output logic [ST_W-1:0]  status_o
);
    always_comb begin
        status_o = status_i;
        if (to_s_i) begin
            status_o[ST_SPIE] = status_i[ST_SIE];
            status_o[ST_SPP]  = priv_i[0];
            status_o[ST_SIE]  = 1'b0;
        end else begin
            status_o[ST_MPIE]          = status_i[ST_MIE];
            status_o[ST_MPP+1:ST_MPP]  = priv_i;
            status_o[ST_MIE]           = 1'b0;
        end
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter int               CAUSE_W   = 6,
    parameter logic [XLEN-1:0]  TVAL_MASK = 32'h0000_B0F3,
    parameter bit               VECTORED  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_valid_i,
    input  logic                trap_irq_i,
    input  logic [CAUSE_W-1:0]  trap_cause_i,
    input  logic [XLEN-1:0]     trap_addr_i,
    input  logic [XLEN-1:0]     trap_pc_i,
    input  logic [1:0]          priv_i,
    input  logic [ST_W-1:0]     status_i,
    input  logic [XLEN-1:0]     edeleg_i,
    input  logic [XLEN-1:0]     ideleg_i,
    input  logic [XLEN-1:0]     svec_i,
    input  logic [XLEN-1:0]     mvec_i,
    output logic [ST_W-1:0]     status_o,
    output logic [1:0]          priv_o,
    output logic [XLEN-1:0]     scause_o,
    output logic [XLEN-1:0]     sepc_o,
    output logic [XLEN-1:0]     stval_o,
    output logic [XLEN-1:0]     mcause_o,
    output logic [XLEN-1:0]     mepc_o,
    output logic [XLEN-1:0]     mtval_o,
    output logic                redir_valid_o,
    output logic [XLEN-1:0]     redir_pc_o
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    typedef struct packed {
        logic [ST_W-1:0]  status;
        logic [1:0]       priv;
        logic [XLEN-1:0]  scause;
        logic [XLEN-1:0]  sepc;
        logic [XLEN-1:0]  stval;
        logic [XLEN-1:0]  mcause;
        logic [XLEN-1:0]  mepc;
        logic [XLEN-1:0]  mtval;
        logic             redir_valid;
        logic [XLEN-1:0]  redir_pc;
    } state_t;

    state_t st_q, st_d;

    logic [CAUSE_W-1:0]  eff_cause;
    logic                to_s;
    logic                keep_tval;
    logic [XLEN-1:0]     vec_base;
    logic [XLEN-1:0]     vec_pc;
    logic [ST_W-1:0]     next_status;
    logic [XLEN-1:0]     cause_word;
    logic [XLEN-1:0]     tval_word;

    trap_route #(
        .XLEN      (XLEN),
        .CAUSE_W   (CAUSE_W),
        .TVAL_MASK (TVAL_MASK)
    ) u_route (
        .irq_i       (trap_irq_i),
        .cause_i     (trap_cause_i),
        .priv_i      (priv_i),
        .edeleg_i    (edeleg_i),
        .ideleg_i    (ideleg_i),
        .cause_o     (eff_cause),
        .to_s_o      (to_s),
        .keep_tval_o (keep_tval)
    );

    assign vec_base = to_s ? svec_i : mvec_i;

    trap_vector #(
        .XLEN     (XLEN),
        .CAUSE_W  (CAUSE_W),
        .VECTORED (VECTORED)
    ) u_vector (
        .base_i  (vec_base),
        .irq_i   (trap_irq_i),
        .cause_i (eff_cause),
        .pc_o    (vec_pc)
    );

    trap_status u_status (
        .to_s_i   (to_s),
        .priv_i   (priv_i),
        .status_i (status_i),
        .status_o (next_status)
    );

    assign cause_word = {trap_irq_i, {PAD_W{1'b0}}, eff_cause};
    assign tval_word  = keep_tval ? trap_addr_i : '0;

    always_comb begin
        st_d             = st_q;
        st_d.redir_valid = 1'b0;
        if (trap_valid_i) begin
            st_d.redir_valid = 1'b1;
            st_d.redir_pc    = vec_pc;
            st_d.status      = next_status;
            if (to_s) begin
                st_d.priv   = PRIV_S;
                st_d.scause = cause_word;
                st_d.sepc   = trap_pc_i;
                st_d.stval  = tval_word;
            end else begin
                st_d.priv   = PRIV_M;
                st_d.mcause = cause_word;
                st_d.mepc   = trap_pc_i;
                st_d.mtval  = tval_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o      = st_q.status;
    assign priv_o        = st_q.priv;
    assign scause_o      = st_q.scause;
    assign sepc_o        = st_q.sepc;
    assign stval_o       = st_q.stval;
    assign mcause_o      = st_q.mcause;
    assign mepc_o        = st_q.mepc;
    assign mtval_o       = st_q.mtval;
    assign redir_valid_o = st_q.redir_valid;
    assign redir_pc_o    = st_q.redir_pc;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_valid_i,
    input logic             trap_irq_i,
    input logic [1:0]       priv_i,
    input logic [XLEN-1:0]  trap_pc_i,
    input logic [ST_W-1:0]  status_o,
    input logic [1:0]       priv_o,
    input logic [XLEN-1:0]  scause_o,
    input logic [XLEN-1:0]  sepc_o,
    input logic [XLEN-1:0]  mcause_o,
    input logic [XLEN-1:0]  mepc_o,
    input logic             redir_valid_o,
    input logic [XLEN-1:0]  redir_pc_o
);
    a_r1_m_stays_m: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && priv_i == PRIV_M) |=> (priv_o == PRIV_M));

    a_r4_irq_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && trap_irq_i) |=>
            ((priv_o == PRIV_M) ? mcause_o[XLEN-1] : scause_o[XLEN-1]));

    a_r5_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=>
            ((priv_o == PRIV_M) ? !status_o[ST_MIE] : !status_o[ST_SIE]));

    a_r7_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=>
            ((priv_o == PRIV_M) ? (mepc_o == $past(trap_pc_i))
                                : (sepc_o == $past(trap_pc_i))));

    a_r8_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> (redir_pc_o[1:0] == 2'b00));

    a_r9_pulse_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> redir_valid_o);

    a_r9_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> !redir_valid_o);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> ($stable(status_o) && $stable(priv_o) &&
                           $stable(mepc_o) && $stable(sepc_o) &&
                           $stable(mcause_o) && $stable(scause_o)));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_valid_i  (trap_valid_i),
    .trap_irq_i    (trap_irq_i),
    .priv_i        (priv_i),
    .trap_pc_i     (trap_pc_i),
    .status_o      (status_o),
    .priv_o        (priv_o),
    .scause_o      (scause_o),
    .sepc_o        (sepc_o),
    .mcause_o      (mcause_o),
    .mepc_o        (mepc_o),
    .redir_valid_o (redir_valid_o),
    .redir_pc_o    (redir_pc_o)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid_i = 1'b0;
    logic        trap_irq_i = 1'b0;
    logic [5:0]  trap_cause_i = '0;
    logic [31:0] trap_addr_i = '0;
    logic [31:0] trap_pc_i = '0;
    logic [1:0]  priv_i = '0;
    logic [6:0]  status_i = '0;
    logic [31:0] edeleg_i = '0;
    logic [31:0] ideleg_i = '0;
    logic [31:0] svec_i = '0;
    logic [31:0] mvec_i = '0;
    logic [6:0]  status_o;
    logic [1:0]  priv_o;
    logic [31:0] scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
    logic        redir_valid_o;
    logic [31:0] redir_pc_o;

    always #10 clk = ~clk;

    trap_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i),
        .trap_irq_i(trap_irq_i), .trap_cause_i(trap_cause_i),
        .trap_addr_i(trap_addr_i), .trap_pc_i(trap_pc_i), .priv_i(priv_i),
        .status_i(status_i), .edeleg_i(edeleg_i), .ideleg_i(ideleg_i),
        .svec_i(svec_i), .mvec_i(mvec_i), .status_o(status_o),
        .priv_o(priv_o), .scause_o(scause_o), .sepc_o(sepc_o),
        .stval_o(stval_o), .mcause_o(mcause_o), .mepc_o(mepc_o),
        .mtval_o(mtval_o), .redir_valid_o(redir_valid_o),
        .redir_pc_o(redir_pc_o)
    );

    typedef struct {
        logic [6:0]  st;
        logic [1:0]  pv;
        logic [31:0] sc, se, stv, mc, me, mtv, pc;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t model;
    exp_t last;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   done   = 1'b0;

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_trap(input logic irq, input logic [5:0] cause,
                             input logic [31:0] addr, input logic [31:0] pc,
                             input logic [1:0] priv, input logic [6:0] st,
                             input logic [31:0] ed, input logic [31:0] id,
                             input logic [31:0] sv, input logic [31:0] mv,
                             input string tag);
        logic [5:0]  c;
        logic [31:0] mask, vec, tv, cw;
        bit          to_s, keep;
        @(negedge clk);
        c = cause;
        if (!irq && c == 6'd8)
            c = (priv == 2'd3) ? 6'd11 : (priv == 2'd1) ? 6'd9 : 6'd8;
        mask = irq ? id : ed;
        to_s = (priv == 2'd0 || priv == 2'd1) && (c < 6'd32) && mask[c[4:0]];
        case (c)
            6'd0, 6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd13, 6'd15: keep = !irq;
            default: keep = 1'b0;
        endcase
        tv  = keep ? addr : 32'h0;
        cw  = {irq, 25'h0, c};
        vec = to_s ? sv : mv;
        model.pc = {vec[31:2], 2'b00} + ((irq && vec[1:0] == 2'b01) ? {24'h0, c, 2'b00} : 32'h0);
        model.st = st;
        if (to_s) begin
            model.st[2] = st[0];
            model.st[4] = priv[0];
            model.st[0] = 1'b0;
            model.pv = 2'd1;
            model.sc = cw; model.se = pc; model.stv = tv;
        end else begin
            model.st[3] = st[1];
            model.st[6:5] = priv;
            model.st[1] = 1'b0;
            model.pv = 2'd3;
            model.mc = cw; model.me = pc; model.mtv = tv;
        end
        model.tag = tag;
        q.push_back(model);
        trap_valid_i = 1'b1; trap_irq_i = irq; trap_cause_i = cause;
        trap_addr_i = addr; trap_pc_i = pc; priv_i = priv; status_i = st;
        edeleg_i = ed; ideleg_i = id; svec_i = sv; mvec_i = mv;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trap_valid_i = 1'b0;
            trap_cause_i = 6'h3F; trap_addr_i = 32'hDEAD_0000; trap_pc_i = 32'hBAD0_0000;
            status_i = 7'h7F;
        end
    endtask

    // Monitor: pops the scoreboard on each redirect pulse; otherwise checks hold (R10)
    always @(negedge clk) begin
        if (mon_on) begin
            if (redir_valid_o) begin
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected redirect actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    cmp(e.tag, "priv", {30'h0, priv_o}, {30'h0, e.pv});
                    cmp(e.tag, "status", {25'h0, status_o}, {25'h0, e.st});
                    cmp(e.tag, "scause", scause_o, e.sc);
                    cmp(e.tag, "sepc", sepc_o, e.se);
                    cmp(e.tag, "stval", stval_o, e.stv);
                    cmp(e.tag, "mcause", mcause_o, e.mc);
                    cmp(e.tag, "mepc", mepc_o, e.me);
                    cmp(e.tag, "mtval", mtval_o, e.mtv);
                    cmp(e.tag, "redirect pc", redir_pc_o, e.pc);
                    last = e;
                end
            end else begin
                cmp("R10", "idle priv", {30'h0, priv_o}, {30'h0, last.pv});
                cmp("R10", "idle status", {25'h0, status_o}, {25'h0, last.st});
                cmp("R10", "idle mepc", mepc_o, last.me);
                cmp("R10", "idle stval", stval_o, last.stv);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model = '{st: 7'h0, pv: 2'd3, sc: 0, se: 0, stv: 0, mc: 0, me: 0, mtv: 0, pc: 0, tag: "R11"};
        last = model;
        repeat (3) @(negedge clk);
        // R11 reset state
        cmp("R11", "priv", {30'h0, priv_o}, 32'd3);
        cmp("R11", "status", {25'h0, status_o}, 32'h0);
        cmp("R11", "mcause", mcause_o, 32'h0);
        cmp("R11", "scause", scause_o, 32'h0);
        cmp("R11", "redir_valid", {31'h0, redir_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R3 R1: ecall from U delegated by bit 8, no trap value (R6)
        push_trap(0, 6'd8, 32'h1111_0000, 32'h0000_1000, 2'd0, 7'h01,
                  32'h0000_0100, 32'h0, 32'h8000_0000, 32'h9000_0000, "R1/R3/R6");
        idle(2);
        // R3: ecall from S, bit 9 clear, goes to M with cause 9 (R5 mpp=1)
        push_trap(0, 6'd8, 32'h0, 32'h0000_2000, 2'd1, 7'h03,
                  32'h0000_0100, 32'h0, 32'h8000_0000, 32'h9000_0000, "R3/R5");
        idle(1);
        // R1 R3: ecall from M with all delegated stays in M, cause 11
        push_trap(0, 6'd8, 32'h0, 32'h0000_3000, 2'd3, 7'h02,
                  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h9000_0004, "R1/R3");
        idle(1);
        // R6: load page fault delegated to S keeps address
        push_trap(0, 6'd13, 32'hCAFE_0123, 32'h0000_4000, 2'd0, 7'h05,
                  32'h0000_2000, 32'h0, 32'h8000_0100, 32'h9000_0000, "R6/R1");
        // R6 R10: store access fault to M back to back, S words hold
        push_trap(0, 6'd7, 32'hBEEF_0456, 32'h0000_5000, 2'd1, 7'h03,
                  32'h0000_2000, 32'h0, 32'h8000_0100, 32'h9000_0000, "R6/R10");
        // R6: illegal instruction gives zero trap value
        push_trap(0, 6'd2, 32'h1234_5678, 32'h0000_6000, 2'd1, 7'h00,
                  32'h0000_0004, 32'h0, 32'h8000_0200, 32'h9000_0000, "R6");
        idle(1);
        // R2 R8 R4: interrupt 5 delegated by ideleg, vectored S base
        push_trap(1, 6'd5, 32'hAAAA_AAAA, 32'h0000_7000, 2'd0, 7'h01,
                  32'h0, 32'h0000_0020, 32'h8000_0301, 32'h9000_0000, "R2/R8/R4");
        idle(1);
        // R2: interrupt 7 with only edeleg bit set goes to M, vectored M base
        push_trap(1, 6'd7, 32'h0, 32'h0000_8000, 2'd0, 7'h03,
                  32'h0000_0080, 32'h0, 32'h8000_0000, 32'h9000_0401, "R2/R8");
        // R8: exception with vectored base gets no offset
        push_trap(0, 6'd2, 32'h0, 32'h0000_9000, 2'd3, 7'h02,
                  32'h0, 32'h0, 32'h8000_0000, 32'h9000_0501, "R8");
        // R8: mode bits 3 with interrupt give no offset, bits cleared
        push_trap(1, 6'd3, 32'h0, 32'h0000_A000, 2'd3, 7'h02,
                  32'h0, 32'h0, 32'h8000_0000, 32'h9000_0603, "R8");
        idle(1);
        // R1: cause 40 aliases set bit 8 but is out of range, goes to M
        push_trap(0, 6'd40, 32'h5555_0000, 32'h0000_B000, 2'd0, 7'h01,
                  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h9000_0700, "R1");
        idle(1);
        // R3: interrupt cause 8 from S not remapped, delegated
        push_trap(1, 6'd8, 32'h0, 32'h0000_C000, 2'd1, 7'h01,
                  32'h0, 32'h0000_0100, 32'h8000_0801, 32'h9000_0000, "R3/R4");
        idle(1);
        // R7 R5: S trap from S records previous privilege 1
        push_trap(0, 6'd12, 32'h7777_0000, 32'h0000_D004, 2'd1, 7'h7D,
                  32'h0000_1000, 32'h0, 32'h8000_0900, 32'h9000_0000, "R5/R7");
        idle(4);

        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9 pending items actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule